// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt and Bus-Master Status Logic

This block holds the interrupt and bus-master state of both channels of a two-channel IDE host. Each channel takes a drive interrupt line and pulses that report the end of a DMA transfer or a DMA fault. From these it keeps a transfer-active flag, a sticky error flag and an interrupt-pending flag. It also drives one interrupt request per channel and one "transfer finished cleanly" indication per channel.

Software reaches the state through a byte-wide register port. Reads are combinational. Writes take effect on the next rising clock edge. A channel's interrupt-pending flag is one bit of storage, but it is visible in three places: the channel's bus-master status register, a per-channel configuration byte, and a shared mirror register. The mirror register also holds one mask bit per channel. Acknowledging the interrupt through any one of these views clears the single flag, so none of the three can be left stale.

Register map, by address: 0 is the command for channel 0 and 1 is the status for channel 0. 2 is the command for channel 1 and 3 is the status for channel 1. 4 is the configuration byte for channel 0, 5 is the configuration byte for channel 1, and 6 is the mirror register.

Top module: `ide_irq_status`

## Requirements
- R1: After reset, every command, status and configuration register reads 0x00, and each status register shows only its simplex input at bit 7. The mirror register reads 0x30, with both channels masked. Both interrupt outputs are low and the read-line mode output is low.
- R2: A rising edge on a channel's drive interrupt input sets that channel's pending flag at the next clock edge. The flag then reads as 1 in three places: status bit 2, the channel's configuration bit (bit 1 at address 4 for channel 0, bit 4 at address 5 for channel 1), and mirror bit 2 (channel 0) or bit 3 (channel 1). Holding the input high does not set the flag again.
- R3: A channel's interrupt output is high exactly when its pending flag is set and its mask bit is clear.
- R4: Writing a status register with bit 2 set clears that channel's pending flag in all three views. Writing 0 to bit 2 leaves the flag unchanged.
- R5: Writing 1 to the channel's configuration bit clears the pending flag in all three views. All other bits written to addresses 4 and 5 have no effect.
- R6: Writing 1 to mirror bit 2 or bit 3 clears the pending flag of channel 0 or channel 1 respectively, and leaves the other channel's flag alone.
- R7: If a drive interrupt edge and a clearing write to the same channel occur in the same cycle, the flag ends up set.
- R8: Command bit 0 is the start bit and reads back as written. Writing 1 while the start bit is 0 sets status bit 0 (active). Writing 1 while it is already 1 does not re-arm active. Writing 0 clears both the start bit and active.
- R9: A DMA-done pulse clears active. A DMA-error pulse sets status bit 1 (error) and clears active. Writing 1 to status bit 1 clears error, except that an error pulse in the same cycle wins.
- R10: A channel's clean-finish output is high exactly when the low three status bits read 100b.
- R11: Status bits 5 and 6 are read/write capability flags. Status bit 7 reflects the channel's simplex input, and writes to it are ignored. Status bits 3 and 4 read 0.
- R12: Mirror bit 1 is write-only. It drives the read-line mode output and always reads back as 0.
- R13: Mirror bits 4 and 5 are read/write mask bits for channels 0 and 1.
- R14: Addresses 7 and above read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_irq_i | input | 2 | Drive interrupt line per channel |
| dma_done_i | input | 2 | One-cycle pulse: transfer finished, per channel |
| dma_err_i | input | 2 | One-cycle pulse: transfer fault, per channel |
| simplex_i | input | 2 | Simplex/disabled indication per channel, shown at status bit 7 |
| reg_addr_i | input | 4 | Register address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Combinational read data for reg_addr_i |
| irq_o | output | 2 | Interrupt request per channel |
| xfer_ok_o | output | 2 | Clean-finish indication per channel |
| rd_line_mode_o | output | 1 | Write-only mode bit from the mirror register |

## Verification
Two functions can act in the same clock: a new drive interrupt edge and an acknowledge write to the same channel, and likewise an error pulse and an error-clear write. The bench lowers the drive line for one cycle and then raises it in the very cycle that carries a clearing write. It does this through the status view and again through the configuration view, and it also fires an error pulse together with an error-clear write. In every case the set must survive. A behavioural model applies set-over-clear and is compared with the read port and all outputs on every clock.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;

   // Bus-master status byte, most significant field first
   typedef struct packed {
      logic       simplex;
      logic [1:0] dma_cap;
      logic [1:0] rsvd;
      logic       irq;
      logic       err;
      logic       act;
   } bm_stat_t;

   localparam int ST_ACT        = 0;
   localparam int ST_ERR        = 1;
   localparam int ST_IRQ        = 2;
   localparam int ST_CAP_LO     = 5;
   localparam int ST_CAP_HI     = 6;

   localparam int MIRR_ADDR     = 6;
   localparam int MIRR_MODE_BIT = 1;
   localparam int MIRR_BLK_BASE = 4;

   function automatic int cmd_addr(input int ch);
      return 2 * ch;
   endfunction

   function automatic int stat_addr(input int ch);
      return 2 * ch + 1;
   endfunction

   function automatic int cfg_addr(input int ch);
      return 4 + ch;
   endfunction

   function automatic int cfg_irq_bit(input int ch);
      return (ch == 0) ? 1 : 4;
   endfunction

   function automatic int mirr_pend_bit(input int ch);
      return 2 + ch;
   endfunction

   function automatic int mirr_blk_bit(input int ch);
      return MIRR_BLK_BASE + ch;
   endfunction

endpackage

// File: rtl/ide_chan_status.sv
module ide_chan_status
   import ide_irq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       drive_irq_i,
   input  logic       dma_done_i,
   input  logic       dma_err_i,
   input  logic       simplex_i,
   input  logic       cmd_we_i,
   input  logic       cmd_start_i,
   input  logic       cap_we_i,
   input  logic [1:0] cap_i,
   input  logic       err_w1c_i,
   input  logic       irq_w1c_i,
   input  logic       block_i,
   output logic       start_o,
   output bm_stat_t   stat_o,
   output logic       pend_o,
   output logic       irq_o,
   output logic       xfer_ok_o
);

   logic       drv_prev_q;
   logic       irq_q;
   logic       err_q;
   logic       act_q;
   logic       start_q;
   logic [1:0] cap_q;
   logic       drv_rise;
   logic       go;
   logic       halt;

   assign drv_rise = drive_irq_i & ~drv_prev_q;
   assign go       = cmd_we_i & cmd_start_i & ~start_q;
   assign halt     = cmd_we_i & ~cmd_start_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_prev_q <= 1'b0;
         irq_q      <= 1'b0;
         err_q      <= 1'b0;
         act_q      <= 1'b0;
         start_q    <= 1'b0;
         cap_q      <= '0;
      end else begin
         drv_prev_q <= drive_irq_i;
         if (cmd_we_i) start_q <= cmd_start_i;
         act_q <= go | (act_q & ~halt & ~dma_done_i & ~dma_err_i);
         err_q <= dma_err_i | (err_q & ~err_w1c_i);
         irq_q <= drv_rise | (irq_q & ~irq_w1c_i);
         if (cap_we_i) cap_q <= cap_i;
      end
   end

   always_comb begin
      stat_o         = '0;
      stat_o.act     = act_q;
      stat_o.err     = err_q;
      stat_o.irq     = irq_q;
      stat_o.dma_cap = cap_q;
      stat_o.simplex = simplex_i;
   end

   assign start_o   = start_q;
   assign pend_o    = irq_q;
   assign irq_o     = irq_q & ~block_i;
   assign xfer_ok_o = stat_o.irq & ~stat_o.err & ~stat_o.act;

   AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_irq_i && !drv_prev_q) |=> pend_o);                      // R7

   AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      dma_err_i |=> (stat_o.err && !stat_o.act));                    // R9

   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o.err && !err_w1c_i) |=> stat_o.err);                    // R9

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_done_i && !(cmd_we_i && cmd_start_i)) |=> !stat_o.act);   // R9

endmodule

// File: rtl/ide_reg_decode.sv
module ide_reg_decode
   import ide_irq_pkg::*;
#(
   parameter int NCHAN = 2,
   parameter int AW    = 4,
   parameter int DW    = 8
) (
   input  logic [AW-1:0]            addr_i,
   input  logic                     we_i,
   input  logic [DW-1:0]            wdata_i,
   input  logic [NCHAN-1:0]         start_i,
   input  logic [NCHAN-1:0][DW-1:0] stat_i,
   input  logic [NCHAN-1:0]         pend_i,
   input  logic [NCHAN-1:0]         blk_i,
   output logic [NCHAN-1:0]         cmd_we_o,
   output logic [NCHAN-1:0]         cap_we_o,
   output logic [NCHAN-1:0]         err_w1c_o,
   output logic [NCHAN-1:0]         irq_w1c_o,
   output logic                     mirr_we_o,
   output logic [DW-1:0]            rdata_o
);

   logic unused_wbits;
   assign unused_wbits = ^{wdata_i[DW-1:5], wdata_i[0]};

   assign mirr_we_o = we_i & (addr_i == AW'(MIRR_ADDR));

   for (genvar c = 0; c < NCHAN; c++) begin : g_strobe
      localparam int CA = cmd_addr(c);
      localparam int SA = stat_addr(c);
      localparam int FA = cfg_addr(c);
      localparam int FB = cfg_irq_bit(c);
      localparam int PB = mirr_pend_bit(c);
      logic cfg_hit;
      assign cfg_hit      = we_i & (addr_i == AW'(FA));
      assign cmd_we_o[c]  = we_i & (addr_i == AW'(CA));
      assign cap_we_o[c]  = we_i & (addr_i == AW'(SA));
      assign err_w1c_o[c] = cap_we_o[c] & wdata_i[ST_ERR];
      assign irq_w1c_o[c] = (cap_we_o[c] & wdata_i[ST_IRQ])
                          | (cfg_hit & wdata_i[FB])
                          | (mirr_we_o & wdata_i[PB]);
   end

   always_comb begin
      rdata_o = '0;
      for (int c = 0; c < NCHAN; c++) begin
         if (addr_i == AW'(cmd_addr(c)))  rdata_o[0] = start_i[c];
         if (addr_i == AW'(stat_addr(c))) rdata_o = stat_i[c];
         if (addr_i == AW'(cfg_addr(c)))  rdata_o[cfg_irq_bit(c)] = pend_i[c];
      end
      if (addr_i == AW'(MIRR_ADDR)) begin
         for (int c = 0; c < NCHAN; c++) begin
            rdata_o[mirr_pend_bit(c)] = pend_i[c];
            rdata_o[mirr_blk_bit(c)]  = blk_i[c];
         end
      end
   end

endmodule

// File: rtl/ide_mirror_ctl.sv
module ide_mirror_ctl #(
   parameter int NCHAN = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [NCHAN-1:0] blk_wr_i,
   input  logic             mode_wr_i,
   output logic [NCHAN-1:0] blk_o,
   output logic             mode_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_o  <= '1;
         mode_o <= 1'b0;
      end else if (we_i) begin
         blk_o  <= blk_wr_i;
         mode_o <= mode_wr_i;
      end
   end

   AST_BLK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (blk_o == $past(blk_wr_i)));                          // R13

   AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (mode_o == $past(mode_wr_i)));                        // R12

endmodule

// File: rtl/ide_irq_status.sv
module ide_irq_status
   import ide_irq_pkg::*;
#(
   parameter int NCHAN  = 2,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCHAN-1:0]  drive_irq_i,
   input  logic [NCHAN-1:0]  dma_done_i,
   input  logic [NCHAN-1:0]  dma_err_i,
   input  logic [NCHAN-1:0]  simplex_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic              reg_we_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic [NCHAN-1:0]  irq_o,
   output logic [NCHAN-1:0]  xfer_ok_o,
   output logic              rd_line_mode_o
);

   if (NCHAN != 2) begin : g_bad_nchan
      $error("ide_irq_status: bit layout fixes NCHAN at 2");
   end
   if (DATA_W != 8) begin : g_bad_dw
      $error("ide_irq_status: register port must be one byte wide");
   end
   if (ADDR_W < 3) begin : g_bad_aw
      $error("ide_irq_status: ADDR_W too small for seven registers");
   end

   logic [NCHAN-1:0]             cmd_we;
   logic [NCHAN-1:0]             cap_we;
   logic [NCHAN-1:0]             err_w1c;
   logic [NCHAN-1:0]             irq_w1c;
   logic                         mirr_we;
   logic [NCHAN-1:0]             start;
   logic [NCHAN-1:0]             pend;
   logic [NCHAN-1:0]             blk;
   logic [NCHAN-1:0][DATA_W-1:0] stat_b;
   bm_stat_t                     stat_s [NCHAN];

   ide_reg_decode #(.NCHAN(NCHAN), .AW(ADDR_W), .DW(DATA_W)) u_decode (
      .addr_i    (reg_addr_i),
      .we_i      (reg_we_i),
      .wdata_i   (reg_wdata_i),
      .start_i   (start),
      .stat_i    (stat_b),
      .pend_i    (pend),
      .blk_i     (blk),
      .cmd_we_o  (cmd_we),
      .cap_we_o  (cap_we),
      .err_w1c_o (err_w1c),
      .irq_w1c_o (irq_w1c),
      .mirr_we_o (mirr_we),
      .rdata_o   (reg_rdata_o)
   );

   ide_mirror_ctl #(.NCHAN(NCHAN)) u_mirror (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_i      (mirr_we),
      .blk_wr_i  (reg_wdata_i[MIRR_BLK_BASE +: NCHAN]),
      .mode_wr_i (reg_wdata_i[MIRR_MODE_BIT]),
      .blk_o     (blk),
      .mode_o    (rd_line_mode_o)
   );

   for (genvar c = 0; c < NCHAN; c++) begin : g_chan
      localparam int CA = cmd_addr(c);
      localparam int SA = stat_addr(c);
      localparam int FA = cfg_addr(c);
      localparam int FB = cfg_irq_bit(c);
      localparam int PB = mirr_pend_bit(c);

      ide_chan_status u_chan (
         .clk         (clk),
         .rst_n       (rst_n),
         .drive_irq_i (drive_irq_i[c]),
         .dma_done_i  (dma_done_i[c]),
         .dma_err_i   (dma_err_i[c]),
         .simplex_i   (simplex_i[c]),
         .cmd_we_i    (cmd_we[c]),
         .cmd_start_i (reg_wdata_i[0]),
         .cap_we_i    (cap_we[c]),
         .cap_i       (reg_wdata_i[ST_CAP_HI:ST_CAP_LO]),
         .err_w1c_i   (err_w1c[c]),
         .irq_w1c_i   (irq_w1c[c]),
         .block_i     (blk[c]),
         .start_o     (start[c]),
         .stat_o      (stat_s[c]),
         .pend_o      (pend[c]),
         .irq_o       (irq_o[c]),
         .xfer_ok_o   (xfer_ok_o[c])
      );

      assign stat_b[c] = stat_s[c];

      AST_STAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_we_i && reg_addr_i == ADDR_W'(SA) && reg_wdata_i[ST_IRQ]
          && !drive_irq_i[c]) |=> !pend[c]);                         // R4

      AST_CFG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_we_i && reg_addr_i == ADDR_W'(FA) && reg_wdata_i[FB]
          && !drive_irq_i[c]) |=> !pend[c]);                         // R5

      AST_MIRR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_we_i && reg_addr_i == ADDR_W'(MIRR_ADDR) && reg_wdata_i[PB]
          && !drive_irq_i[c]) |=> !pend[c]);                         // R6

      AST_BLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         blk[c] |-> !irq_o[c]);                                      // R3

      AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_we_i && reg_addr_i == ADDR_W'(CA) && !reg_wdata_i[0])
         |=> (!stat_s[c].act && !start[c]));                         // R8
   end

endmodule

// File: tb/ide_irq_status_tb.sv
`timescale 1ns/1ps
module ide_irq_status_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] drv = '0;
   logic [1:0] done = '0;
   logic [1:0] err = '0;
   logic [1:0] simp = '0;
   logic [3:0] addr = '0;
   logic       we = 1'b0;
   logic [7:0] wd = '0;
   logic [7:0] rd;
   logic [1:0] irq;
   logic [1:0] ok;
   logic       mode;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   ide_irq_status dut_i (
      .clk(clk), .rst_n(rst_n), .drive_irq_i(drv), .dma_done_i(done),
      .dma_err_i(err), .simplex_i(simp), .reg_addr_i(addr), .reg_we_i(we),
      .reg_wdata_i(wd), .reg_rdata_o(rd), .irq_o(irq), .xfer_ok_o(ok),
      .rd_line_mode_o(mode)
   );

   // behavioural reference state
   bit       m_start [2];
   bit       m_act   [2];
   bit       m_err   [2];
   bit       m_irq   [2];
   bit [1:0] m_cap   [2];
   bit       m_prev  [2];
   bit       m_blk   [2] = '{1'b1, 1'b1};
   bit       m_mode  = 1'b0;

   function automatic logic [7:0] stat_of(input int c);
      return {simp[c], m_cap[c], 2'b00, m_irq[c], m_err[c], m_act[c]};
   endfunction

   function automatic logic [7:0] mread(input logic [3:0] a);
      case (a)
         4'd0: return {7'd0, m_start[0]};
         4'd1: return stat_of(0);
         4'd2: return {7'd0, m_start[1]};
         4'd3: return stat_of(1);
         4'd4: return {6'd0, m_irq[0], 1'b0};
         4'd5: return {3'd0, m_irq[1], 4'd0};
         4'd6: return {2'b00, m_blk[1], m_blk[0], m_irq[1], m_irq[0], 2'b00};
         default: return 8'h00;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 2; c++) begin
            m_start[c] = 0; m_act[c] = 0; m_err[c] = 0; m_irq[c] = 0;
            m_cap[c] = 0; m_prev[c] = 0; m_blk[c] = 1;
         end
         m_mode = 0;
      end else begin
         for (int c = 0; c < 2; c++) begin
            bit rise, go, halt, clr;
            int cbit;
            cbit = (c == 0) ? 1 : 4;
            rise = drv[c] && !m_prev[c];
            m_prev[c] = drv[c];
            go   = we && addr == 4'(2*c) && wd[0] && !m_start[c];
            halt = we && addr == 4'(2*c) && !wd[0];
            if (we && addr == 4'(2*c)) m_start[c] = wd[0];
            m_act[c] = go || (m_act[c] && !halt && !done[c] && !err[c]);
            m_err[c] = err[c] || (m_err[c] && !(we && addr == 4'(2*c+1) && wd[1]));
            clr = (we && addr == 4'(2*c+1) && wd[2])
               || (we && addr == 4'(4+c) && wd[cbit])
               || (we && addr == 4'd6 && wd[2+c]);
            m_irq[c] = rise || (m_irq[c] && !clr);
            if (we && addr == 4'(2*c+1)) m_cap[c] = wd[6:5];
         end
         if (we && addr == 4'd6) begin
            m_blk[0] = wd[4];
            m_blk[1] = wd[5];
            m_mode   = wd[1];
         end
      end
   end

   task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         cmp("R14 read port", rd, mread(addr));
         cmp("R3 irq_o", {6'd0, irq}, {6'd0, m_irq[1] & !m_blk[1], m_irq[0] & !m_blk[0]});
         cmp("R10 xfer_ok_o", {6'd0, ok},
             {6'd0, m_irq[1] & !m_err[1] & !m_act[1], m_irq[0] & !m_err[0] & !m_act[0]});
         cmp("R12 mode", {7'd0, mode}, {7'd0, m_mode});
      end
   end

   task automatic step();
      @(negedge clk); #1;
      we = 0; done = '0; err = '0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      step(); addr = a; we = 1; wd = d;
   endtask

   task automatic setdrv(input int c, input logic v);
      step(); drv[c] = v;
   endtask

   task automatic rdk(input logic [3:0] a, input logic [7:0] exp, input string tag);
      step(); addr = a;
      @(negedge clk);
      cmp(tag, rd, exp);
   endtask

   task automatic outk(input logic [7:0] act_sel, input logic [7:0] exp, input string tag);
      cmp(tag, act_sel, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1;
      // R1 reset state
      rdk(4'd6, 8'h30, "R1 mirror");
      rdk(4'd1, 8'h00, "R1 stat0");
      rdk(4'd3, 8'h00, "R1 stat1");
      outk({6'd0, irq}, 8'h00, "R1 irq_o");
      // R2 edge sets all views, masked output stays low
      setdrv(0, 1);
      rdk(4'd1, 8'h04, "R2 stat0 irq");
      rdk(4'd4, 8'h02, "R2 cfg0");
      rdk(4'd6, 8'h34, "R2 mirror");
      outk({6'd0, irq}, 8'h00, "R3 masked");
      // R13 unmask
      wr(4'd6, 8'h00);
      rdk(4'd6, 8'h04, "R13 mask clear");
      outk({6'd0, irq}, 8'h01, "R3 unmasked");
      // R4 status W1C
      wr(4'd1, 8'h00);
      rdk(4'd1, 8'h04, "R4 write zero");
      wr(4'd1, 8'h04);
      rdk(4'd1, 8'h00, "R4 stat view");
      rdk(4'd4, 8'h00, "R4 cfg view");
      rdk(4'd6, 8'h00, "R4 mirror view");
      rdk(4'd1, 8'h00, "R2 level no retrigger");
      // R5 cfg W1C
      setdrv(0, 0); setdrv(0, 1);
      rdk(4'd4, 8'h02, "R2 second edge");
      wr(4'd4, 8'hFD);
      rdk(4'd4, 8'h02, "R5 other bits ignored");
      wr(4'd4, 8'h02);
      rdk(4'd6, 8'h00, "R5 cfg0 clear");
      setdrv(1, 1);
      rdk(4'd5, 8'h10, "R5 cfg1 set");
      rdk(4'd6, 8'h08, "R2 ch1 mirror");
      wr(4'd5, 8'h10);
      rdk(4'd3, 8'h00, "R5 cfg1 clear");
      // R6 mirror W1C per channel
      setdrv(1, 0); setdrv(0, 0); setdrv(0, 1); setdrv(1, 1);
      rdk(4'd6, 8'h0C, "R6 both pending");
      wr(4'd6, 8'h08);
      rdk(4'd6, 8'h04, "R6 ch1 only");
      // R7 set wins over same-cycle clear
      setdrv(0, 0);
      step(); drv[0] = 1; addr = 4'd1; we = 1; wd = 8'h04;
      rdk(4'd1, 8'h04, "R7 stat clear collision");
      setdrv(0, 0);
      step(); drv[0] = 1; addr = 4'd4; we = 1; wd = 8'h02;
      rdk(4'd4, 8'h02, "R7 cfg clear collision");
      // R8 start / stop
      wr(4'd0, 8'h01);
      rdk(4'd0, 8'h01, "R8 start reads back");
      rdk(4'd1, 8'h05, "R8 active set");
      step(); done[0] = 1;
      rdk(4'd1, 8'h04, "R9 done clears active");
      wr(4'd0, 8'h01);
      rdk(4'd1, 8'h04, "R8 no re-arm");
      wr(4'd0, 8'h00);
      rdk(4'd0, 8'h00, "R8 stop");
      wr(4'd0, 8'h01);
      rdk(4'd1, 8'h05, "R8 restart");
      // R9 error
      step(); err[0] = 1;
      rdk(4'd1, 8'h06, "R9 error sets");
      outk({6'd0, ok}, 8'h00, "R10 error blocks ok");
      wr(4'd1, 8'h02);
      rdk(4'd1, 8'h04, "R9 error clear");
      outk({6'd0, ok}, 8'h01, "R10 clean finish");
      step(); err[0] = 1; addr = 4'd1; we = 1; wd = 8'h02;
      rdk(4'd1, 8'h06, "R9 error set wins");
      wr(4'd1, 8'h02);
      // R11 capability and simplex bits
      step(); simp[1] = 1;
      rdk(4'd3, 8'h80, "R11 simplex");
      wr(4'd3, 8'hFF);
      rdk(4'd3, 8'hE0, "R11 cap bits");
      // R12 write-only bit
      wr(4'd6, 8'h02);
      rdk(4'd6, 8'h04, "R12 reads zero");
      outk({7'd0, mode}, 8'h01, "R12 mode out");
      wr(4'd6, 8'h30);
      rdk(4'd6, 8'h34, "R13 masks set");
      outk({6'd0, irq}, 8'h00, "R3 masked again");
      // R14 unused address
      wr(4'd9, 8'hFF);
      rdk(4'd9, 8'h00, "R14 unused reads 0");
      rdk(4'd6, 8'h34, "R14 no side effect");
      rdk(4'd2, 8'h00, "R14 ch1 cmd untouched");
      repeat (3) step();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(4 * 20000);
      if (!finished) begin
         finished = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule